// File: doc/BRIEF.md
# SMBus Register-Bank Slave

This block is a two-wire serial slave that gives a bus controller read and write access to a small bank of 8-bit configuration registers. The register contents are always present on a parallel output, so they can steer other logic directly. The registers load parameter-defined defaults at reset, so the surrounding logic works without any serial traffic.

A system clock samples SCL and SDA. The block detects start, repeated start and stop conditions, and it pulls SDA low through an output-enable, since the line is open-drain. The command byte picks one of two access modes. With its top bit set, the access is a single read or write at the offset held in the low seven bits. With its top bit clear, the access is a block transfer that starts at offset zero and walks upward. A block write carries a byte count from the master. On a block read the slave itself sends the count, which is the number of implemented registers, before it sends the data.

Top module: `smbus_regbank`

## Requirements
- R1: The slave acknowledges only the address bytes 0xD2 (write) and 0xD3 (read), which are the 7-bit address 0x69 followed by the R/W bit in bit 0. Any other address is not acknowledged, and the rest of that transaction is ignored until the next start or stop.
- R2: A command byte with bit 7 = 1 selects single-byte access. Bits 6:0 give the register offset. A following data byte is written to that register, or a repeated start with a read returns that register.
- R3: A command byte of 0x00 (bit 7 = 0) selects block access, starting at register offset 0.
- R4: A block write is sent as address, command, byte count and then data bytes. The slave acknowledges each of them. Data bytes go to consecutive registers, starting at offset 0.
- R5: A block read is sent as address with write, command, repeated start and address with read. The slave then sends the count (the number of registers) followed by the registers from offset 0 upward. Every byte is sent most significant bit first.
- R6: A register changes only when the acknowledge bit of its data byte is clocked. A transfer that stops after any complete byte keeps the bytes already written. A transfer that is aborted in the middle of a byte changes no register.
- R7: After reset every register holds its default value and SDA is released.
- R8: When the master answers a read byte with NACK, the slave releases SDA and stays quiet until a stop or a new start.
- R9: Writes to an offset at or beyond the number of registers are acknowledged and discarded. Reads from such an offset return 0x00.
- R10: Data bytes of a block write that go past the last register are acknowledged and ignored.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High to pull SDA low (open-drain drive) |
| regs_o | output | NREG*8 | Register bank, register i in bits 8i+7:8i |

## Verification
Every bus event reaches the logic three system clocks after the pad changes: two synchronizer stages plus one edge-detect stage. So a register update appears three clocks after the SCL rise of its acknowledge bit, and the slave's SDA drive changes three clocks after an SCL fall. The bench holds each SCL phase for ten clocks and reads SDA in the middle of the high phase, well after the drive has settled. The reference copy of the registers is compared with the outputs on every clock. The comparison is paused only during the high phase of an acknowledge bit, and the model is updated once that phase ends, so the three-clock commit delay never shows up as a mismatch.

// File: rtl/smbus_regbank.sv
module smbus_regbank #(
  parameter int              NREG      = 8,
  parameter logic [6:0]      DEV_ADDR  = 7'h69,
  parameter logic [NREG*8-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o
);
  localparam int         IW  = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [7:0] NR8 = 8'(NREG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WR, S_TX, S_WAIT} st_t;

  st_t        state;
  logic [2:0] scl_s, sda_s;
  logic [7:0] sh, tx;
  logic [3:0] bitcnt;
  logic [6:0] ptr;
  logic       blk, mack;
  logic [7:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  logic scl, sda, scl_rise, scl_fall, start_c, stop_c, in_rng, addr_hit;
  logic [7:0] rd_val;
  logic [6:0] ptr_nx;
  assign scl      = scl_s[1];
  assign sda      = sda_s[1];
  assign scl_rise = scl & ~scl_s[2];
  assign scl_fall = ~scl & scl_s[2];
  assign start_c  = scl & scl_s[2] & sda_s[2] & ~sda;
  assign stop_c   = scl & scl_s[2] & ~sda_s[2] & sda;
  assign in_rng   = {1'b0, ptr} < NR8;
  assign rd_val   = in_rng ? regs[ptr[IW-1:0]] : 8'h00;
  assign ptr_nx   = (&ptr) ? ptr : ptr + 7'd1;
  assign addr_hit = (sh[7:1] == DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      sh     <= '0;
      tx     <= '0;
      ptr    <= '0;
      blk    <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= RESET_VAL[i*8 +: 8];
    end else if (start_c) begin
      state  <= S_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (state != S_IDLE && state != S_WAIT) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          sh     <= {sh[6:0], sda};
          bitcnt <= bitcnt + 4'd1;
        end else begin
          bitcnt <= 4'd9;
          mack   <= ~sda;
          case (state)
            S_CMD: begin
              blk <= ~sh[7];
              ptr <= sh[7] ? sh[6:0] : 7'd0;
            end
            S_WR: begin
              if (in_rng) regs[ptr[IW-1:0]] <= sh;
              ptr <= ptr_nx;
            end
            default: ;
          endcase
        end
      end else if (scl_fall) begin
        if (state == S_TX) begin
          if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
            tx     <= tx << 1;
            sda_oe <= ~tx[6];
          end else if (bitcnt == 4'd8) begin
            sda_oe <= 1'b0;
          end else if (bitcnt == 4'd9) begin
            if (mack) begin
              tx     <= rd_val;
              sda_oe <= ~rd_val[7];
              ptr    <= ptr_nx;
              bitcnt <= '0;
            end else begin
              state  <= S_WAIT;
              sda_oe <= 1'b0;
            end
          end
        end else if (bitcnt == 4'd8) begin
          sda_oe <= (state != S_ADDR) || addr_hit;
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          sda_oe <= 1'b0;
          case (state)
            S_ADDR:
              if (!addr_hit) state <= S_WAIT;
              else if (sh[0]) begin
                state <= S_TX;
                if (blk) begin
                  tx     <= NR8;
                  sda_oe <= ~NR8[7];
                end else begin
                  tx     <= rd_val;
                  sda_oe <= ~rd_val[7];
                  ptr    <= ptr_nx;
                end
              end else state <= S_CMD;
            S_CMD:   state <= blk ? S_CNT : S_WR;
            default: state <= S_WR;
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*8 +: 8] = regs[g];
  end

  p_quiet_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE || state == S_WAIT) |-> !sda_oe);

  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl);

  p_commit_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_o != $past(regs_o)) |-> $past(state == S_WR && scl_rise && bitcnt == 4'd8));

  p_discard_oor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state == S_WR && scl_rise && bitcnt == 4'd8 && !in_rng) |-> (regs_o == $past(regs_o)));
endmodule

// File: tb/sim_smbus_regbank.sv
module sim_smbus_regbank;
  localparam int NREG = 8;
  localparam logic [63:0] DEF = 64'h8877665544332211;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic sda_oe, sda_line;
  logic [NREG*8-1:0] regs_o;
  int ncmp = 0, nbad = 0, viol = 0;
  bit cmp_en = 0, prev_oe = 0;
  logic [7:0] model [NREG];

  always #5 clk = ~clk;
  assign sda_line = ~(m_low | sda_oe);

  smbus_regbank #(.NREG(NREG), .DEV_ADDR(7'h69), .RESET_VAL(DEF)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o));

  function automatic logic [NREG*8-1:0] packm();
    logic [NREG*8-1:0] p;
    for (int i = 0; i < NREG; i++) p[i*8 +: 8] = model[i];
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    ncmp++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_en) chk(regs_o == packm(), "R6 per-clock register model", regs_o, packm());
    if (rst_n && scl && (sda_oe != prev_oe)) viol++;
    prev_oe = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    m_low = 0; tick(5); scl = 1; tick(10); m_low = 1; tick(10); scl = 0; tick(5);
  endtask

  task automatic bstop();
    m_low = 1; tick(5); scl = 1; tick(10); m_low = 0; tick(10);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      tick(5); m_low = ~b[i]; tick(5); scl = 1; tick(10); scl = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int idx, output bit ack);
    send_bits(b, 8);
    tick(5); m_low = 0; tick(5);
    cmp_en = 0; scl = 1; tick(5); ack = (sda_line == 1'b0); tick(5); scl = 0; tick(1);
    if (idx >= 0 && idx < NREG) model[idx] = b;
    cmp_en = 1;
  endtask

  task automatic recv_byte(input bit ack_it, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(10); scl = 1; tick(5); b[i] = sda_line; tick(5); scl = 0;
    end
    tick(5); m_low = ack_it; tick(5); scl = 1; tick(10); scl = 0; tick(5); m_low = 0;
  endtask

  initial begin
    bit a;
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) model[i] = DEF[i*8 +: 8];
    tick(5); rst_n = 1; tick(5);
    chk(regs_o == DEF, "R7 reset defaults", regs_o, DEF);
    chk(sda_oe == 0, "R7 sda released", sda_oe, 0);
    cmp_en = 1;

    bstart(); send_byte(8'hD2, -1, a); chk(a, "R1 ack 0xD2", a, 1);
    send_byte(8'h83, -1, a); chk(a, "R2 ack command", a, 1);
    send_byte(8'hA5, 3, a); chk(a, "R2 ack data", a, 1);
    bstop(); chk(regs_o[31:24] == 8'hA5, "R2 byte write", regs_o[31:24], 8'hA5);

    bstart(); send_byte(8'hD2, -1, a); send_byte(8'h83, -1, a);
    bstart(); send_byte(8'hD3, -1, a); chk(a, "R1 ack 0xD3", a, 1);
    recv_byte(0, d); chk(d == 8'hA5, "R2 byte read", d, 8'hA5);
    tick(3); chk(sda_oe == 0, "R8 release after NACK", sda_oe, 0);
    bstop();

    bstart(); send_byte(8'hA0, -1, a); chk(!a, "R1 nack other address", a, 0);
    send_byte(8'h83, -1, a); chk(!a, "R1 ignore rest", a, 0);
    send_byte(8'h5A, -1, a); chk(!a, "R1 ignore data", a, 0);
    bstop();
    bstart(); send_byte(8'hD4, -1, a); chk(!a, "R1 nack 0xD4", a, 0); bstop();
    chk(regs_o[31:24] == 8'hA5, "R1 no change", regs_o[31:24], 8'hA5);

    bstart(); send_byte(8'hD2, -1, a); send_byte(8'h00, -1, a); chk(a, "R3 block command", a, 1);
    send_byte(8'h03, -1, a); chk(a, "R4 count ack", a, 1);
    send_byte(8'h10, 0, a); send_byte(8'h20, 1, a); send_byte(8'h30, 2, a);
    chk(a, "R4 data ack", a, 1); bstop();
    chk(regs_o[23:0] == 24'h302010, "R4 block write", regs_o[23:0], 24'h302010);

    bstart(); send_byte(8'hD2, -1, a); send_byte(8'h00, -1, a);
    bstart(); send_byte(8'hD3, -1, a);
    recv_byte(1, d); chk(d == NREG, "R5 block count", d, NREG);
    for (int i = 0; i < NREG; i++) begin
      recv_byte(i != NREG - 1, d); chk(d == model[i], "R5 block read data", d, model[i]);
    end
    bstop();

    bstart(); send_byte(8'hD2, -1, a); send_byte(8'h00, -1, a); send_byte(8'h05, -1, a);
    send_byte(8'hC1, 0, a); send_byte(8'hC2, 1, a); bstop();
    chk(regs_o[23:0] == 24'h30C2C1, "R6 early stop", regs_o[23:0], 24'h30C2C1);

    bstart(); send_byte(8'hD2, -1, a); send_byte(8'h84, -1, a);
    send_bits(8'hFF, 4); bstop();
    chk(regs_o[39:32] == 8'h55, "R6 mid-byte abort", regs_o[39:32], 8'h55);

    bstart(); send_byte(8'hD2, -1, a); send_byte(8'hD0, -1, a);
    send_byte(8'h77, -1, a); chk(a, "R9 out-of-range ack", a, 1); bstop();
    chk(regs_o == packm(), "R9 discarded", regs_o, packm());
    bstart(); send_byte(8'hD2, -1, a); send_byte(8'hD0, -1, a);
    bstart(); send_byte(8'hD3, -1, a); recv_byte(0, d);
    chk(d == 8'h00, "R9 out-of-range read", d, 0); bstop();

    bstart(); send_byte(8'hD2, -1, a); send_byte(8'h00, -1, a); send_byte(8'h0A, -1, a);
    for (int i = 0; i < 10; i++) begin
      send_byte(8'hE0 + 8'(i), i, a); chk(a, "R10 long block ack", a, 1);
    end
    bstop();
    chk(regs_o == packm(), "R10 long block result", regs_o, packm());

    chk(viol == 0, "R11 drive only with SCL low", viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    ncmp++; nbad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule